// File: doc/BRIEF.md
# Bidirectional Toggle-Stage Binary Counter

This block is a small synchronous binary counter that counts either upward or downward, steered by a single direction input. Every state bit is held in its own toggle stage, and all stages share one clock. Instead of feeding the state through an adder or subtractor, each stage has a toggle-enable term. The counter computes that term from the stages below it and from the direction line, and a stage flips on a clock edge exactly when its term is true.

The default width is three bits, so the counter walks a modulo-8 cycle in either direction and wraps at both ends. The width is a parameter, and the toggle terms are built as two running AND chains over the lower bits, one for the upward case and one for the downward case. The reset input is asynchronous and active low. The counter is cleared as soon as the reset input goes low, and its release is brought onto the clock through a short synchronizer before counting resumes.

Top module: `updown_toggle_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 000, whatever the clock and `dir_up` are doing. The clear does not wait for a clock edge.
- R2: After `rst_n` rises between two clock edges, `count` stays at 000 through the next two rising edges. The first change happens on the third rising edge.
- R3: When `dir_up` is 1 at a rising edge, `count` becomes its old value plus one, modulo 2^WIDTH.
- R4: When `dir_up` is 0 at a rising edge, `count` becomes its old value minus one, modulo 2^WIDTH.
- R5: Counting upward from all ones (111) gives all zeros (000).
- R6: Counting downward from all zeros (000) gives all ones (111).
- R7: Bit 0 of `count` inverts on every rising edge once reset has been released.
- R8: When counting up, bit i (i ≥ 1) inverts only if every lower bit was 1. When counting down, it inverts only if every lower bit was 0. Otherwise it holds.
- R9: A change of `dir_up` is used at the very next rising edge. The first step after the change moves one count in the new direction from the current value, and no state is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for all stages |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dir_up | input | 1 | Direction: 1 counts upward, 0 counts downward |
| count | output | WIDTH | Current counter state, bit 0 least significant |

## Verification
The bound checker checks on every cycle after reset release that each step is plus or minus one according to the direction sampled at that edge. It also checks that bit 0 always inverts, that each upper bit inverts only under its AND-chain condition, that the counter reads zero while reset is low, and that it stays zero while the synchronizer is still holding it. Only the directed scenarios can show the whole-cycle behaviour: full walks in both directions with wraps at both ends, mid-sequence reversals that land on the right neighbour, the exact two-edge delay after reset release, and an asynchronous clear that arrives between clock edges.

// File: rtl/updown_toggle_pkg.sv
package updown_toggle_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;

  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/utc_reset_sync.sv
module utc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/utc_toggle_logic.sv
module utc_toggle_logic
  import updown_toggle_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] state,
  input  logic             dir_up,
  output logic [WIDTH-1:0] toggle
);

  dir_e dir;
  // ones_below[i]: all bits below i are 1; zeros_below[i]: all are 0
  logic [WIDTH-1:0] ones_below;
  logic [WIDTH-1:0] zeros_below;

  assign dir = dir_e'(dir_up);
  assign ones_below[0]  = 1'b1;
  assign zeros_below[0] = 1'b1;
  assign toggle[0]      = 1'b1;

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_stage_term
      assign ones_below[i]  = ones_below[i-1]  &  state[i-1];
      assign zeros_below[i] = zeros_below[i-1] & ~state[i-1];
      assign toggle[i] = ((dir == DIR_UP)   & ones_below[i]) |
                         ((dir == DIR_DOWN) & zeros_below[i]);
    end
  endgenerate

endmodule

// File: rtl/utc_toggle_stage.sv
module utc_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl,
  output logic q
);

  logic q_next;

  always_comb begin
    q_next = q;
    if (tgl) q_next = ~q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end

endmodule

// File: rtl/updown_toggle_counter.sv
module updown_toggle_counter
  import updown_toggle_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_up,
  output logic [WIDTH-1:0] count
);

  logic             run_n;
  logic [WIDTH-1:0] tgl;
  logic [WIDTH-1:0] state;

  utc_reset_sync #(
    .STAGES (RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (run_n)
  );

  utc_toggle_logic #(
    .WIDTH (WIDTH)
  ) u_tgl_logic (
    .state  (state),
    .dir_up (dir_up),
    .toggle (tgl)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      utc_toggle_stage u_stage (
        .clk   (clk),
        .rst_n (run_n),
        .tgl   (tgl[i]),
        .q     (state[i])
      );
    end
  endgenerate

  assign count = state;

endmodule

// File: rtl/updown_toggle_counter_chk.sv
module updown_toggle_counter_chk #(
  parameter int unsigned WIDTH = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_n,
  input logic             dir_up,
  input logic [WIDTH-1:0] count
);

  // armed: the previous edge saw the counter out of reset
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= run_n;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> count == '0);

  a_r2_sync_hold: assert property (@(posedge clk)
    !run_n |-> count == '0);

  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n || !run_n)
    (armed && $past(dir_up)) |-> count == WIDTH'($past(count) + 1'b1));

  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n || !run_n)
    (armed && !$past(dir_up)) |-> count == WIDTH'($past(count) - 1'b1));

  a_r7_lsb_flips: assert property (@(posedge clk) disable iff (!rst_n || !run_n)
    armed |-> count[0] != $past(count[0]));

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_r8
      a_r8_upper_toggle: assert property (@(posedge clk) disable iff (!rst_n || !run_n)
        armed |-> ((count[i] != $past(count[i])) ==
                   ($past(dir_up) ? (&$past(count[i-1:0])) : ~(|$past(count[i-1:0])))));
    end
  endgenerate

endmodule

bind updown_toggle_counter updown_toggle_counter_chk #(
  .WIDTH (WIDTH)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run_n  (run_n),
  .dir_up (dir_up),
  .count  (count)
);

// File: tb/tb_updown_toggle_counter.sv
`timescale 1ns/1ps
module tb_updown_toggle_counter;

  localparam int unsigned W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dir_up = 1'b1;
  logic [W-1:0] count;
  logic [W-1:0] model;
  int           n_checks = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  updown_toggle_counter #(.WIDTH(W)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_up (dir_up),
    .count  (count)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%b expected=%b at %0t", req, got, exp, $time);
    end
  endtask

  // one clock step: drive direction, advance to next falling edge, compare
  task automatic step(input logic up, input string req);
    logic [W-1:0] prev;
    prev   = model;
    dir_up = up;
    @(negedge clk);
    model = up ? W'(prev + 1'b1) : W'(prev - 1'b1);
    check(req, count, model);
    n_checks++;
    if (count[0] === prev[0]) begin
      n_fail++;
      $display("FAIL R7: bit0=%b expected=%b", count[0], ~prev[0]);
    end
  endtask

  task automatic t_reset_release;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", count, '0);
    rst_n = 1'b1;
    dir_up = 1'b1;
    @(negedge clk);
    check("R2", count, '0);
    @(negedge clk);
    check("R2", count, '0);
    model = '0;
  endtask

  task automatic t_full_up;
    for (int k = 0; k < 16; k++) step(1'b1, (model == 3'b111) ? "R5" : "R3");
  endtask

  task automatic t_full_down;
    for (int k = 0; k < 16; k++) step(1'b0, (model == 3'b000) ? "R6" : "R4");
  endtask

  task automatic t_reversals;
    // mid-sequence direction changes, with R8 carry/borrow patterns
    step(1'b1, "R9"); step(1'b1, "R9"); step(1'b1, "R8");
    step(1'b0, "R9"); step(1'b0, "R8"); step(1'b1, "R9");
    step(1'b0, "R9"); step(1'b1, "R9"); step(1'b1, "R8");
    step(1'b1, "R8"); step(1'b0, "R9"); step(1'b0, "R8");
    for (int k = 0; k < 10; k++) step(k[0], "R9");
  endtask

  task automatic t_async_clear;
    step(1'b1, "R3"); step(1'b1, "R3");
    #1.0 rst_n = 1'b0;
    #0.5 check("R1", count, '0);
    @(negedge clk);
    check("R1", count, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", count, '0);
    @(negedge clk);
    check("R2", count, '0);
    model = '0;
    step(1'b0, "R6");
  endtask

  initial begin
    @(negedge clk);
    t_reset_release();
    t_full_up();
    t_full_down();
    t_reversals();
    t_async_clear();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule